// File: doc/BRIEF.md
# Power-Fail Deselect and Write-Protect Controller

This block sits between a memory's external control pins and the memory array, and keeps the array safe while the supply is out of range. It takes two flags from analog comparators: one says the supply is below the power-fail threshold, the other says it is below the lower level where the battery must take over. Both flags arrive without a clock relationship, so each passes through a synchronizer before use. While the power-fail condition holds, the memory is deselected. Writes are blocked, output drive is off, and the active-low chip, write and output enables have no effect.

When the supply comes back above the power-fail threshold, access does not resume at once. A recovery counter must first count a set number of system clocks with the flag clear. If the flag returns before the count is done, the count starts again from zero. A write in progress when power fails is cut off in the same cycle that deselect takes effect. Only the byte being written can be damaged. The battery-select output follows the synchronized low-supply flag in both directions.

The analog comparators and the power switch are not part of the block. The block drives only their digital control.

Top module: `pwrGateTop`

## Requirements
- R1: While `rstN` is low, and after reset until recovery completes, `memSel`, `memWe` and `memOe` are 0. Both synchronizers reset to the asserted value, so `battSel` is 1 during reset.
- R2: Let the first rising edge that samples `pfailRaw` high be edge 1. From edge SYNC_STAGES onward, and for as long as the flag stays high, `memSel`, `memWe` and `memOe` are 0.
- R3: A write held active (`ceN`=0, `weN`=0) when power fails is cut off. `memWe` falls in the same cycle as `memSel` and never outlasts it.
- R4: Let the first rising edge that samples `pfailRaw` low be edge 1. If the flag then stays low, access is enabled right after edge SYNC_STAGES+RECOVER_CYCLES and not earlier.
- R5: If the synchronized power-fail flag is seen high during recovery, even for a single cycle, the recovery count restarts from zero.
- R6: `battSel` equals `lowRaw` delayed by SYNC_STAGES rising edges, in both the rising and the falling direction.
- R7: While access is enabled, the outputs are active-high:
  - `memSel` = !`ceN`
  - `memWe` = !`ceN` & !`weN`
  - `memOe` = !`ceN` & !`oeN` & `weN`, so output drive is off during a write.
- R8: While deselected, every combination of `ceN`, `weN` and `oeN` leaves `memSel`, `memWe` and `memOe` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pfailRaw | input | 1 | Comparator flag: supply below the power-fail threshold (asynchronous) |
| lowRaw | input | 1 | Comparator flag: supply below the battery switchover level (asynchronous) |
| ceN | input | 1 | External chip enable, active low |
| weN | input | 1 | External write enable, active low |
| oeN | input | 1 | External output enable, active low |
| memSel | output | 1 | Internal array select, active high |
| memWe | output | 1 | Internal write strobe, active high |
| memOe | output | 1 | Data output drive enable, active high |
| battSel | output | 1 | Select battery as the power source, active high |

## Verification
The bench targets these corner cases:
- **Recovery boundary.** It counts edges to the exact cycle where access returns. A counter that is off by one, or that skips the synchronizer latency, re-enables the memory one cycle early or late.
- **Single-cycle power-fail glitch in mid-recovery.** A design that pauses the count instead of restarting it reopens the memory too soon.
- **Write held active as power fails.** A design that lets the write strobe outlive the select writes during brown-out.
- **All enable combinations while deselected and while open.** These catch an input that leaks through the gate, or output drive left on during a write.

// File: rtl/pwrgate_pkg.sv
package pwrgate_pkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic gateOpen;   // memory access allowed
    logic battOn;     // run from battery
  } ctlStrobe_t;
endpackage

// File: rtl/pwrSync.sv
module pwrSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pwrGateCtrl.sv
module pwrGateCtrl
  import pwrgate_pkg::*;
#(
  parameter int RECOVER_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pfailRaw,
  input  logic       lowRaw,
  output ctlStrobe_t strobe
);
  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RECOVER_CYCLES);

  logic pfHold;
  logic lowHold;
  logic [CNT_W-1:0] holdCnt;
  logic holdDone;

  pwrSync #(.STAGES(SYNC_STAGES)) u_pfSync (
    .clk(clk), .rstN(rstN), .din(pfailRaw), .dout(pfHold));
  pwrSync #(.STAGES(SYNC_STAGES)) u_lowSync (
    .clk(clk), .rstN(rstN), .din(lowRaw), .dout(lowHold));

  assign holdDone = (holdCnt == CNT_END);

  // Recovery hold-off: cleared by any synchronized power-fail
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          holdCnt <= '0;
    else if (pfHold)    holdCnt <= '0;
    else if (!holdDone) holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    strobe.gateOpen = !pfHold && holdDone;
    strobe.battOn   = lowHold;
  end
endmodule

// File: rtl/pwrGateDp.sv
module pwrGateDp
  import pwrgate_pkg::*;
(
  input  ctlStrobe_t strobe,
  input  logic       ceN,
  input  logic       weN,
  input  logic       oeN,
  output logic       memSel,
  output logic       memWe,
  output logic       memOe,
  output logic       battSel
);
  always_comb begin
    memSel  = strobe.gateOpen && !ceN;
    memWe   = memSel && !weN;
    memOe   = memSel && !oeN && weN;
    battSel = strobe.battOn;
  end
endmodule

// File: rtl/pwrGateTop.sv
module pwrGateTop
  import pwrgate_pkg::*;
#(
  parameter int RECOVER_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pfailRaw,
  input  logic lowRaw,
  input  logic ceN,
  input  logic weN,
  input  logic oeN,
  output logic memSel,
  output logic memWe,
  output logic memOe,
  output logic battSel
);
  ctlStrobe_t strobe;

  pwrGateCtrl #(.RECOVER_CYCLES(RECOVER_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pfailRaw(pfailRaw), .lowRaw(lowRaw), .strobe(strobe));

  pwrGateDp u_dp (
    .strobe(strobe), .ceN(ceN), .weN(weN), .oeN(oeN),
    .memSel(memSel), .memWe(memWe), .memOe(memOe), .battSel(battSel));
endmodule

// File: rtl/pwrGateChk.sv
module pwrGateChk (
  input logic clk,
  input logic rstN,
  input logic pfailRaw,
  input logic lowRaw,
  input logic ceN,
  input logic memSel,
  input logic memWe,
  input logic memOe,
  input logic battSel
);
  p_we_needs_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memSel);

  p_no_drive_in_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memOe));

  p_sel_needs_ce_r8: assert property (@(posedge clk) disable iff (!rstN)
    memSel |-> !ceN);

  p_pfail_deselects_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pfailRaw, 1) && $past(pfailRaw, 2)) |-> !memSel);

  p_batt_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lowRaw, 1) && $past(lowRaw, 2)) |-> battSel);
endmodule

bind pwrGateTop pwrGateChk u_chk (
  .clk(clk), .rstN(rstN), .pfailRaw(pfailRaw), .lowRaw(lowRaw), .ceN(ceN),
  .memSel(memSel), .memWe(memWe), .memOe(memOe), .battSel(battSel));

// File: tb/pwrGateTop_bench.sv
module pwrGateTop_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfailRaw = 1'b1, lowRaw = 1'b1;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic memSel, memWe, memOe, battSel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  pwrGateTop #(.RECOVER_CYCLES(N), .SYNC_STAGES(STG)) u_pwrGateTop (
    .clk(clk), .rstN(rstN), .pfailRaw(pfailRaw), .lowRaw(lowRaw),
    .ceN(ceN), .weN(weN), .oeN(oeN),
    .memSel(memSel), .memWe(memWe), .memOe(memOe), .battSel(battSel));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: flag delay lines and a hold counter
  bit pfQ[$];
  bit lowQ[$];
  int mCnt;

  initial begin
    for (int i = 0; i < STG; i++) begin
      pfQ.push_back(1'b1);
      lowQ.push_back(1'b1);
    end
    mCnt = 0;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STG; i++) begin
        pfQ[i] = 1'b1;
        lowQ[i] = 1'b1;
      end
      mCnt = 0;
    end else begin
      if (pfQ[STG-1]) mCnt = 0;
      else if (mCnt < N) mCnt = mCnt + 1;
      void'(pfQ.pop_back());
      pfQ.push_front(pfailRaw);
      void'(lowQ.pop_back());
      lowQ.push_front(lowRaw);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // Compare against the model at every falling edge
  always @(negedge clk) begin
    bit open, eSel;
    cycles++;
    open = !pfQ[STG-1] && (mCnt == N);
    eSel = open && !ceN;
    chk(curReq, "memSel", memSel, eSel);
    chk(curReq, "memWe", memWe, eSel && !weN);
    chk(curReq, "memOe", memOe, eSel && !oeN && weN);
    chk(curReq, "battSel", battSel, lowQ[STG-1]);
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    step(3);
    chk("R1", "memSel in reset", memSel, 1'b0);
    chk("R1", "battSel in reset", battSel, 1'b1);
    ceN = 1'b0;
    pfailRaw = 1'b0;
    lowRaw = 1'b0;
    rstN = 1'b1;

    // R4: exact recovery boundary (first sampling edge is the next posedge)
    curReq = "R4";
    step(STG + N - 1);
    chk("R4", "memSel one edge early", memSel, 1'b0);
    step(1);
    chk("R4", "memSel at boundary", memSel, 1'b1);

    // R7: all enable combinations while open
    curReq = "R7";
    for (int c = 0; c < 8; c++) begin
      {ceN, weN, oeN} = c[2:0];
      step(1);
    end
    ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    step(1);
    chk("R7", "memOe off during write", memOe, 1'b0);
    chk("R7", "memWe on during write", memWe, 1'b1);

    // R3/R2: write held as power fails
    curReq = "R3";
    pfailRaw = 1'b1;
    step(STG - 1);
    chk("R3", "memWe before deselect", memWe, 1'b1);
    step(1);
    chk("R3", "memWe cut off", memWe, 1'b0);
    chk("R2", "memSel deselected", memSel, 1'b0);

    // R8: inputs ignored while deselected
    curReq = "R8";
    for (int c = 0; c < 8; c++) begin
      {ceN, weN, oeN} = c[2:0];
      step(1);
      chk("R8", "memSel ignored", memSel, 1'b0);
      chk("R8", "memOe ignored", memOe, 1'b0);
    end

    // R5: single-cycle glitch mid-recovery restarts the count
    curReq = "R5";
    ceN = 1'b0; weN = 1'b1; oeN = 1'b0;
    pfailRaw = 1'b0;
    step(N / 2);
    pfailRaw = 1'b1;
    step(1);
    pfailRaw = 1'b0;
    step(N / 2 + STG);
    chk("R5", "memSel stays off after glitch", memSel, 1'b0);
    step(N);
    chk("R5", "memSel back after full count", memSel, 1'b1);

    // R6: battery select both directions
    curReq = "R6";
    lowRaw = 1'b1;
    step(STG - 1);
    chk("R6", "battSel before latency", battSel, 1'b0);
    step(1);
    chk("R6", "battSel rises", battSel, 1'b1);
    lowRaw = 1'b0;
    step(STG);
    chk("R6", "battSel falls", battSel, 1'b0);

    // R2: longer outage then return, model follows every cycle
    curReq = "R2";
    pfailRaw = 1'b1;
    step(10);
    curReq = "R4";
    pfailRaw = 1'b0;
    step(N + STG + 4);
    chk("R4", "memSel after second recovery", memSel, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule